// File: doc/BRIEF.md
# Configurable Asynchronous Serial Port

This block is a full-duplex asynchronous serial port that a processor drives through four word-aligned registers. The frame format is chosen at run time. Software sets the integer ratio of the core clock to the bit rate, the word length (8 or 9 data bits), the parity (none, even or odd) and the stop time (one half, one, one and a half or two bit periods). It then writes words to transmit and reads words as they arrive. Each direction has one holding register. A word written while the shifter is busy is sent straight after the current frame, with no idle gap between the two frames.

The receiver waits for a falling edge on the synchronised line and checks that the line is still low half a bit period later. It then samples each later bit in the middle of its period. Status flags report the transmit holding register empty, a received word waiting, overrun, framing error and parity error. A single interrupt output combines the two data flags, each with its own enable bit.

Top module: `async_serial_port`

## Requirements
- R1: The transmit line idles high. Each frame starts with a low start bit held for exactly DIV clock cycles, where DIV is the divisor register value. The data bits follow, least significant first, each held for DIV cycles.
- R2: Control bit 12 selects the word length: 0 gives 8 data bits and 1 gives 9 data bits. The setting applies to both transmit and receive.
- R3: Control bit 10 enables a parity bit after the data and control bit 9 selects odd parity. With even parity the data bits plus the parity bit hold an even number of ones; with odd parity they hold an odd number.
- R4: The stop code in control bits 15:14 sets how long the line is held high after the data or parity bit: code 0 gives DIV cycles, code 1 gives DIV/2, code 2 gives 2*DIV and code 3 gives DIV + DIV/2. A word already in the holding register starts its start bit in the cycle right after the stop time ends.
- R5: The registers sit at byte offsets 0 (status), 4 (data), 8 (divisor) and 12 (control). The divisor reads back as written. The control register reads back only bits 15:14, 13, 12, 10, 9, 7, 5, 3 and 2; all other bits read as zero.
- R6: A write to the data register is accepted only when both control bit 13 (port enable) and control bit 3 (transmit enable) are set. A write that is not accepted changes neither the line nor status bit 7. While control bit 13 is clear, the transmit line stays high.
- R7: Status bit 7 (transmit holding empty) goes low in the cycle after an accepted data write. It returns high one cycle after the shifter takes the word.
- R8: The receiver runs only while control bits 13 and 2 are both set. A low pulse shorter than half a bit period produces no word. Each data bit is sampled at mid-bit.
- R9: Status bit 5 is set when a frame completes. Reading offset 4 returns the word in bits 8:0 and clears status bit 5.
- R10: Status bit 0 (parity error) and status bit 1 (framing error: the first stop bit was sampled low) are rewritten with every received frame.
- R11: Status bit 3 (overrun) is set when a frame completes while status bit 5 is still set. The newer word replaces the held one. Reading offset 4 clears bit 3.
- R12: The interrupt output is high while (status bit 7 AND control bit 7) OR (status bit 5 AND control bit 5).
- R13: After reset the status register reads 0x80, control reads 0, the divisor holds its reset parameter value, the line is high and the interrupt is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (needed for read side effects) |
| addr | input | ADDR_W | Byte address; bits ADDR_W-1:2 select the register |
| wdata | input | REG_W | Write data |
| rdata | output | REG_W | Read data, a combinational function of addr |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| irq | output | 1 | Interrupt request |

## Verification
The transmit line is modelled as a queue of expected levels, one per cycle, and the line is compared on every falling clock edge. The first frame after an accepted write is expected one idle-high cycle after the write edge and then goes low on the following edge. Chained frames are appended with no gap, which checks the stop timing of each code exactly. Status bit 7 is read between the write and the end of the running frame, where it must be low. Received frames are driven a whole bit period at a time. Their flags are read only after the full stop bit plus a settling margin, since a word completes at mid-stop plus the synchroniser delay. A read side effect is checked on the next read one cycle later, and the interrupt is sampled half a cycle after the register edge that changes it.

// File: rtl/asp_pkg.sv
package asp_pkg;
   // control register bit positions
   localparam int C_STOP_LO = 14;
   localparam int C_PORT_EN = 13;
   localparam int C_NINE    = 12;
   localparam int C_PAR_EN  = 10;
   localparam int C_PAR_ODD = 9;
   localparam int C_IE_TX   = 7;
   localparam int C_IE_RX   = 5;
   localparam int C_TX_EN   = 3;
   localparam int C_RX_EN   = 2;
   localparam logic [15:0] CTRL_MASK = 16'hF6AC;

   // status register bit positions
   localparam int S_TXE  = 7;
   localparam int S_RXNE = 5;
   localparam int S_OVR  = 3;
   localparam int S_FE   = 1;
   localparam int S_PE   = 0;

   localparam int WORD_W = 9;

   typedef enum logic [2:0] {
      F_IDLE, F_START, F_DATA, F_PAR, F_STOP
   } frame_st_t;

   typedef struct packed {
      logic       nine;
      logic       par_en;
      logic       par_odd;
      logic [1:0] stop;
   } frame_cfg_t;
endpackage

// File: rtl/asp_sync.sv
module asp_sync #(
   parameter int  STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("asp_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/asp_tx.sv
module asp_tx import asp_pkg::*; #(
   parameter int DIV_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  frame_cfg_t         cfg,
   input  logic [DIV_W-1:0]   div,
   input  logic               hold_full,
   input  logic [WORD_W-1:0]  hold_data,
   output logic               take,
   output logic               txd
);
   localparam int CW = DIV_W + 1;

   frame_st_t         st;
   logic [CW-1:0]     cnt;
   logic [CW-1:0]     bit_len;
   logic [CW-1:0]     stop_len;
   logic [WORD_W-1:0] sh;
   logic [3:0]        bitn;
   logic [3:0]        bit_last;
   logic              par_q;
   logic [WORD_W-1:0] hold_m;
   logic              load_ok;

   assign bit_len  = {1'b0, div};
   assign bit_last = cfg.nine ? 4'd8 : 4'd7;
   assign hold_m   = cfg.nine ? hold_data : {1'b0, hold_data[7:0]};

   always_comb begin
      case (cfg.stop)
         2'd0:    stop_len = {1'b0, div};
         2'd1:    stop_len = {2'b00, div[DIV_W-1:1]};
         2'd2:    stop_len = {div, 1'b0};
         default: stop_len = {1'b0, div} + {2'b00, div[DIV_W-1:1]};
      endcase
   end

   assign load_ok = en && hold_full &&
                    ((st == F_IDLE) || ((st == F_STOP) && (cnt == '0)));
   assign take = load_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= F_IDLE;
         txd   <= 1'b1;
         cnt   <= '0;
         sh    <= '0;
         bitn  <= '0;
         par_q <= 1'b0;
      end else if (!en) begin
         st  <= F_IDLE;
         txd <= 1'b1;
      end else if (load_ok) begin
         st    <= F_START;
         txd   <= 1'b0;
         cnt   <= bit_len - 1'b1;
         sh    <= hold_m;
         par_q <= (^hold_m) ^ cfg.par_odd;
      end else begin
         case (st)
            F_IDLE: txd <= 1'b1;
            F_START: begin
               if (cnt == '0) begin
                  st   <= F_DATA;
                  txd  <= sh[0];
                  sh   <= sh >> 1;
                  bitn <= '0;
                  cnt  <= bit_len - 1'b1;
               end else cnt <= cnt - 1'b1;
            end
            F_DATA: begin
               if (cnt == '0) begin
                  if (bitn == bit_last) begin
                     if (cfg.par_en) begin
                        st  <= F_PAR;
                        txd <= par_q;
                        cnt <= bit_len - 1'b1;
                     end else begin
                        st  <= F_STOP;
                        txd <= 1'b1;
                        cnt <= stop_len - 1'b1;
                     end
                  end else begin
                     txd  <= sh[0];
                     sh   <= sh >> 1;
                     bitn <= bitn + 1'b1;
                     cnt  <= bit_len - 1'b1;
                  end
               end else cnt <= cnt - 1'b1;
            end
            F_PAR: begin
               if (cnt == '0) begin
                  st  <= F_STOP;
                  txd <= 1'b1;
                  cnt <= stop_len - 1'b1;
               end else cnt <= cnt - 1'b1;
            end
            F_STOP: begin
               if (cnt == '0) st <= F_IDLE;
               else           cnt <= cnt - 1'b1;
            end
            default: st <= F_IDLE;
         endcase
      end
   end

   AST_LINE_HIGH_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> txd);  // R6
   AST_STOP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (st == F_STOP) |-> txd);  // R4
endmodule

// File: rtl/asp_rx.sv
module asp_rx import asp_pkg::*; #(
   parameter int DIV_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  frame_cfg_t         cfg,
   input  logic [DIV_W-1:0]   div,
   input  logic               line,
   output logic               done,
   output logic [WORD_W-1:0]  dout,
   output logic               pe,
   output logic               fe
);
   localparam int CW = DIV_W + 1;

   frame_st_t         st;
   logic [CW-1:0]     cnt;
   logic [CW-1:0]     bit_len;
   logic [CW-1:0]     half_len;
   logic [WORD_W-1:0] sh;
   logic [WORD_W-1:0] word;
   logic [3:0]        bitn;
   logic [3:0]        bit_last;
   logic              line_q;
   logic              pbit;

   assign bit_len  = {1'b0, div};
   assign half_len = {2'b00, div[DIV_W-1:1]};
   assign bit_last = cfg.nine ? 4'd8 : 4'd7;
   assign word     = cfg.nine ? sh : {1'b0, sh[WORD_W-1:1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= F_IDLE;
         cnt    <= '0;
         sh     <= '0;
         bitn   <= '0;
         line_q <= 1'b1;
         pbit   <= 1'b0;
         done   <= 1'b0;
         dout   <= '0;
         pe     <= 1'b0;
         fe     <= 1'b0;
      end else begin
         line_q <= line;
         done   <= 1'b0;
         if (!en) begin
            st <= F_IDLE;
         end else begin
            case (st)
               F_IDLE: begin
                  if (line_q && !line) begin
                     st  <= F_START;
                     cnt <= half_len - 1'b1;
                  end
               end
               F_START: begin
                  if (cnt == '0) begin
                     if (!line) begin
                        st   <= F_DATA;
                        cnt  <= bit_len - 1'b1;
                        bitn <= '0;
                     end else st <= F_IDLE;
                  end else cnt <= cnt - 1'b1;
               end
               F_DATA: begin
                  if (cnt == '0) begin
                     sh   <= {line, sh[WORD_W-1:1]};
                     bitn <= bitn + 1'b1;
                     cnt  <= bit_len - 1'b1;
                     if (bitn == bit_last) st <= cfg.par_en ? F_PAR : F_STOP;
                  end else cnt <= cnt - 1'b1;
               end
               F_PAR: begin
                  if (cnt == '0) begin
                     pbit <= line;
                     st   <= F_STOP;
                     cnt  <= bit_len - 1'b1;
                  end else cnt <= cnt - 1'b1;
               end
               F_STOP: begin
                  if (cnt == '0) begin
                     done <= 1'b1;
                     dout <= word;
                     pe   <= cfg.par_en & ((^word) ^ pbit ^ cfg.par_odd);
                     fe   <= !line;
                     st   <= F_IDLE;
                  end else cnt <= cnt - 1'b1;
               end
               default: st <= F_IDLE;
            endcase
         end
      end
   end

   AST_START_CONFIRMED: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == F_DATA) && ($past(st) == F_START)) |-> !$past(line));  // R8
endmodule

// File: rtl/async_serial_port.sv
module async_serial_port import asp_pkg::*; #(
   parameter int ADDR_W      = 4,
   parameter int REG_W       = 32,
   parameter int DIV_W       = 16,
   parameter int DIV_RESET   = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [REG_W-1:0]  wdata,
   output logic [REG_W-1:0]  rdata,
   input  logic              rxd,
   output logic              txd,
   output logic              irq
);
   localparam int IDX_W = ADDR_W - 2;
   localparam logic [IDX_W-1:0] W_STAT = IDX_W'(0);
   localparam logic [IDX_W-1:0] W_DATA = IDX_W'(1);
   localparam logic [IDX_W-1:0] W_DIV  = IDX_W'(2);
   localparam logic [IDX_W-1:0] W_CTRL = IDX_W'(3);

   generate
      if (ADDR_W < 4) begin : g_bad_addr
         $error("async_serial_port: ADDR_W must be at least 4");
      end
      if (REG_W < 16) begin : g_bad_reg
         $error("async_serial_port: REG_W must be at least 16");
      end
      if ((DIV_W < 4) || (DIV_W > REG_W)) begin : g_bad_div
         $error("async_serial_port: DIV_W out of range");
      end
   endgenerate

   logic [IDX_W-1:0]  idx;
   logic [15:0]       ctrl_q;
   logic [DIV_W-1:0]  div_q;
   logic              hold_full;
   logic [WORD_W-1:0] hold_data;
   logic [WORD_W-1:0] rx_word;
   logic              rxne, ovr, pe_q, fe_q;
   logic              tx_en, rx_en, wr_acc, rd_data, take;
   logic              rx_line, rx_done, rx_pe, rx_fe;
   logic [WORD_W-1:0] rx_dout;
   frame_cfg_t        cfg;
   logic              unused_bits;

   assign idx         = addr[ADDR_W-1:2];
   assign unused_bits = ^{addr[1:0], wdata[REG_W-1:16]};
   assign tx_en   = ctrl_q[C_PORT_EN] & ctrl_q[C_TX_EN];
   assign rx_en   = ctrl_q[C_PORT_EN] & ctrl_q[C_RX_EN];
   assign wr_acc  = wr_en && (idx == W_DATA) && tx_en;
   assign rd_data = rd_en && (idx == W_DATA);
   assign cfg     = '{nine:    ctrl_q[C_NINE],
                      par_en:  ctrl_q[C_PAR_EN],
                      par_odd: ctrl_q[C_PAR_ODD],
                      stop:    ctrl_q[C_STOP_LO+1:C_STOP_LO]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         div_q  <= DIV_W'(DIV_RESET);
      end else if (wr_en) begin
         if (idx == W_CTRL) ctrl_q <= wdata[15:0] & CTRL_MASK;
         if (idx == W_DIV)  div_q  <= wdata[DIV_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_full <= 1'b0;
         hold_data <= '0;
      end else if (wr_acc) begin
         hold_full <= 1'b1;
         hold_data <= wdata[WORD_W-1:0];
      end else if (take) begin
         hold_full <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_word <= '0;
         rxne    <= 1'b0;
         ovr     <= 1'b0;
         pe_q    <= 1'b0;
         fe_q    <= 1'b0;
      end else begin
         if (rx_done) begin
            rx_word <= rx_dout;
            pe_q    <= rx_pe;
            fe_q    <= rx_fe;
            rxne    <= 1'b1;
            if (rxne && !rd_data) ovr <= 1'b1;
            else if (rd_data)     ovr <= 1'b0;
         end else if (rd_data) begin
            rxne <= 1'b0;
            ovr  <= 1'b0;
         end
      end
   end

   always_comb begin
      rdata = '0;
      case (idx)
         W_STAT: begin
            rdata[S_TXE]  = !hold_full;
            rdata[S_RXNE] = rxne;
            rdata[S_OVR]  = ovr;
            rdata[S_FE]   = fe_q;
            rdata[S_PE]   = pe_q;
         end
         W_DATA:  rdata[WORD_W-1:0] = rx_word;
         W_DIV:   rdata[DIV_W-1:0]  = div_q;
         W_CTRL:  rdata[15:0]       = ctrl_q;
         default: rdata = '0;
      endcase
   end

   assign irq = (!hold_full & ctrl_q[C_IE_TX]) | (rxne & ctrl_q[C_IE_RX]);

   asp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(rxd), .q(rx_line)
   );

   asp_tx #(.DIV_W(DIV_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .en(tx_en), .cfg(cfg), .div(div_q),
      .hold_full(hold_full), .hold_data(hold_data), .take(take), .txd(txd)
   );

   asp_rx #(.DIV_W(DIV_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .en(rx_en), .cfg(cfg), .div(div_q),
      .line(rx_line), .done(rx_done), .dout(rx_dout), .pe(rx_pe), .fe(rx_fe)
   );

   AST_TXE_CLR_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_acc |=> hold_full);  // R7
   AST_RXNE_CLR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data && !rx_done) |=> !rxne);  // R9
   AST_OVR_ON_LATE_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_done && rxne && !rd_data) |=> ovr);  // R11
endmodule

// File: tb/async_serial_port_bench.sv
module async_serial_port_bench;
   localparam int ADDR_W = 4;
   localparam int REG_W  = 32;
   localparam int DIV_RESET = 16;

   localparam logic [3:0] A_STAT = 4'd0;
   localparam logic [3:0] A_DATA = 4'd4;
   localparam logic [3:0] A_DIV  = 4'd8;
   localparam logic [3:0] A_CTRL = 4'd12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0, rd_en = 1'b0;
   logic [ADDR_W-1:0] addr = '0;
   logic [REG_W-1:0]  wdata = '0;
   logic [REG_W-1:0]  rdata;
   logic rxd = 1'b1;
   logic txd, irq;

   int checks = 0;
   int failures = 0;
   bit exp_q[$];
   string line_req = "R1";

   always #10 clk = ~clk;

   async_serial_port #(.ADDR_W(ADDR_W), .REG_W(REG_W), .DIV_RESET(DIV_RESET))
   u_async_serial_port (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .rxd(rxd), .txd(txd), .irq(irq)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // per-cycle reference of the transmit line
   always @(negedge clk) begin
      bit e;
      if (rst_n && exp_q.size() > 0) begin
         e = exp_q.pop_front();
         checks++;
         if (txd !== e) begin
            failures++;
            $display("FAIL %s txd actual=%b expected=%b", line_req, txd, e);
         end
      end
   end

   task automatic bus_wr(logic [3:0] a, logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(posedge clk);
      #1 wr_en = 1'b0;
   endtask

   task automatic bus_rd(logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      rd_en = 1'b1; addr = a;
      #1 d = rdata;
      @(posedge clk);
      #1 rd_en = 1'b0;
   endtask

   function automatic logic [31:0] mk_ctrl(bit en, int stop, bit nine, bit pen,
                                           bit podd, bit iet, bit ier, bit te, bit re);
      return (32'(stop) << 14) | (32'(en) << 13) | (32'(nine) << 12) |
             (32'(pen) << 10) | (32'(podd) << 9) | (32'(iet) << 7) |
             (32'(ier) << 5) | (32'(te) << 3) | (32'(re) << 2);
   endfunction

   function automatic int stop_cycles(int code, int div);
      case (code)
         0: return div;
         1: return div / 2;
         2: return 2 * div;
         default: return div + div / 2;
      endcase
   endfunction

   task automatic push_n(bit v, int n);
      for (int i = 0; i < n; i++) exp_q.push_back(v);
   endtask

   task automatic push_frame(int data, bit nine, bit pen, bit podd, int stop,
                             int div, bit first);
      int n = nine ? 9 : 8;
      bit par = podd;
      if (first) exp_q.push_back(1'b1);
      push_n(1'b0, div);
      for (int i = 0; i < n; i++) begin
         push_n(data[i], div);
         par ^= data[i];
      end
      if (pen) push_n(par, div);
      push_n(1'b1, stop_cycles(stop, div));
   endtask

   task automatic hold_rx(bit v, int n);
      rxd = v;
      repeat (n) @(negedge clk);
   endtask

   task automatic drive_frame(int data, bit nine, bit pen, bit podd,
                              bit badpar, bit badstop, int div);
      int n = nine ? 9 : 8;
      bit par = podd;
      @(negedge clk);
      hold_rx(1'b0, div);
      for (int i = 0; i < n; i++) begin
         hold_rx(data[i], div);
         par ^= data[i];
      end
      if (pen) hold_rx(par ^ badpar, div);
      hold_rx(!badstop, div);
      hold_rx(1'b1, 3 * div);
   endtask

   task automatic drain();
      wait (exp_q.size() == 0);
      @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [31:0] r;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R13 line idle", 32'(txd), 32'd1);
      chk("R13 irq", 32'(irq), 32'd0);
      bus_rd(A_STAT, r); chk("R13 status", r, 32'h80);
      bus_rd(A_DIV, r);  chk("R13 divisor", r, 32'(DIV_RESET));
      bus_rd(A_CTRL, r); chk("R13 control", r, 32'h0);

      // R5 register map
      bus_wr(A_DIV, 32'd8);
      bus_rd(A_DIV, r); chk("R5 divisor readback", r, 32'd8);
      bus_wr(A_CTRL, 32'hFFFF_FFFF);
      bus_rd(A_CTRL, r); chk("R5 control mask", r, 32'hF6AC);
      bus_wr(A_CTRL, 32'h0);

      // R1 R2 R7: 8N1 back-to-back
      line_req = "R1";
      bus_wr(A_CTRL, mk_ctrl(1, 0, 0, 0, 0, 0, 0, 1, 0));
      bus_wr(A_DATA, 32'h44);
      push_frame(32'h44, 0, 0, 0, 0, 8, 1);
      repeat (3) @(posedge clk);
      bus_wr(A_DATA, 32'hA3);
      push_frame(32'hA3, 0, 0, 0, 0, 8, 0);
      bus_rd(A_STAT, r); chk("R7 holding full", r & 32'h80, 32'h0);
      drain();
      bus_rd(A_STAT, r); chk("R7 holding empty", r, 32'h80);

      // R3 R4: even parity, two stop bits
      line_req = "R3";
      bus_wr(A_CTRL, mk_ctrl(1, 2, 0, 1, 0, 0, 0, 1, 0));
      bus_wr(A_DATA, 32'h35);
      push_frame(32'h35, 0, 1, 0, 2, 8, 1);
      repeat (3) @(posedge clk);
      bus_wr(A_DATA, 32'h07);
      push_frame(32'h07, 0, 1, 0, 2, 8, 0);
      drain();

      // R3 R4: odd parity, half stop
      line_req = "R4";
      bus_wr(A_CTRL, mk_ctrl(1, 1, 0, 1, 1, 0, 0, 1, 0));
      bus_wr(A_DATA, 32'h44);
      push_frame(32'h44, 0, 1, 1, 1, 8, 1);
      repeat (3) @(posedge clk);
      bus_wr(A_DATA, 32'h01);
      push_frame(32'h01, 0, 1, 1, 1, 8, 0);
      drain();

      // R2 R4: nine bits, 1.5 stop, divisor 10
      line_req = "R2";
      bus_wr(A_DIV, 32'd10);
      bus_wr(A_CTRL, mk_ctrl(1, 3, 1, 0, 0, 0, 0, 1, 0));
      bus_wr(A_DATA, 32'h1A5);
      push_frame(32'h1A5, 1, 0, 0, 3, 10, 1);
      repeat (3) @(posedge clk);
      bus_wr(A_DATA, 32'h0F0);
      push_frame(32'h0F0, 1, 0, 0, 3, 10, 0);
      drain();

      // R6: transmit disabled, then port disabled
      line_req = "R6";
      bus_wr(A_DIV, 32'd8);
      bus_wr(A_CTRL, mk_ctrl(1, 0, 0, 0, 0, 0, 0, 0, 0));
      bus_wr(A_DATA, 32'h55);
      push_n(1'b1, 20);
      drain();
      bus_rd(A_STAT, r); chk("R6 ignored write txe", r, 32'h80);
      bus_wr(A_CTRL, mk_ctrl(0, 0, 0, 0, 0, 0, 0, 1, 0));
      bus_wr(A_DATA, 32'h00);
      push_n(1'b1, 20);
      drain();
      bus_wr(A_CTRL, mk_ctrl(1, 0, 0, 0, 0, 0, 0, 1, 0));
      push_n(1'b1, 30);
      drain();
      bus_rd(A_STAT, r); chk("R6 nothing pending", r, 32'h80);

      // R8 R9: receive 8N1
      bus_wr(A_DIV, 32'd16);
      bus_wr(A_CTRL, mk_ctrl(1, 0, 0, 0, 0, 0, 0, 0, 1));
      drive_frame(32'h5A, 0, 0, 0, 0, 0, 16);
      bus_rd(A_STAT, r); chk("R9 rx ready", r, 32'hA0);
      bus_rd(A_DATA, r); chk("R8 rx word", r, 32'h5A);
      bus_rd(A_STAT, r); chk("R9 cleared by read", r, 32'h80);

      // R8 glitch
      @(negedge clk);
      hold_rx(1'b0, 3);
      hold_rx(1'b1, 48);
      bus_rd(A_STAT, r); chk("R8 glitch ignored", r, 32'h80);

      // R8 receiver disabled
      bus_wr(A_CTRL, mk_ctrl(1, 0, 0, 0, 0, 0, 0, 0, 0));
      drive_frame(32'h3C, 0, 0, 0, 0, 0, 16);
      bus_rd(A_STAT, r); chk("R8 rx disabled", r, 32'h80);

      // R10 parity
      bus_wr(A_CTRL, mk_ctrl(1, 0, 0, 1, 0, 0, 0, 0, 1));
      drive_frame(32'hC3, 0, 1, 0, 1, 0, 16);
      bus_rd(A_STAT, r); chk("R10 parity error", r, 32'hA1);
      bus_rd(A_DATA, r); chk("R10 word with bad parity", r, 32'hC3);
      drive_frame(32'h81, 0, 1, 0, 0, 0, 16);
      bus_rd(A_STAT, r); chk("R10 parity ok rewrites", r, 32'hA0);
      bus_rd(A_DATA, r); chk("R3 rx even parity word", r, 32'h81);

      // R10 framing
      bus_wr(A_CTRL, mk_ctrl(1, 0, 0, 0, 0, 0, 0, 0, 1));
      drive_frame(32'h3C, 0, 0, 0, 0, 1, 16);
      bus_rd(A_STAT, r); chk("R10 framing error", r, 32'hA2);
      bus_rd(A_DATA, r); chk("R10 framing word", r, 32'h3C);

      // R11 overrun
      drive_frame(32'h11, 0, 0, 0, 0, 0, 16);
      drive_frame(32'h22, 0, 0, 0, 0, 0, 16);
      bus_rd(A_STAT, r); chk("R11 overrun set", r, 32'hA8);
      bus_rd(A_DATA, r); chk("R11 newest word kept", r, 32'h22);
      bus_rd(A_STAT, r); chk("R11 overrun cleared", r, 32'h80);

      // R2 nine-bit receive
      bus_wr(A_CTRL, mk_ctrl(1, 0, 1, 0, 0, 0, 0, 0, 1));
      drive_frame(32'h1C7, 1, 0, 0, 0, 0, 16);
      bus_rd(A_DATA, r); chk("R2 nine-bit word", r, 32'h1C7);

      // R12 interrupt
      bus_wr(A_CTRL, mk_ctrl(1, 0, 0, 0, 0, 0, 1, 0, 1));
      @(negedge clk); chk("R12 irq idle", 32'(irq), 32'd0);
      drive_frame(32'h66, 0, 0, 0, 0, 0, 16);
      chk("R12 irq on rx", 32'(irq), 32'd1);
      bus_rd(A_DATA, r);
      @(negedge clk); chk("R12 irq after read", 32'(irq), 32'd0);
      bus_wr(A_CTRL, mk_ctrl(1, 0, 0, 0, 0, 1, 0, 0, 0));
      @(negedge clk); chk("R12 irq on txe", 32'(irq), 32'd1);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule